// File: doc/BRIEF.md
# Pipeline hazard detection and forwarding unit

This block is the combinational hazard logic of a five-stage in-order integer pipeline. The stages are fetch, decode and operand read, ALU, data memory, and register write. Each cycle it looks at the instruction class and register fields held in the decode, ALU, memory and write-back stages. From these it drives two things: the select lines of the multiplexers on the two ALU inputs, and a stall. The stall freezes the fetch and decode registers and turns the instruction entering the ALU stage into a nop.

Registers are written only in the last stage, and data memory is touched only in the memory stage. Because of this, only read-after-write hazards need checking. A run-time mode input picks one of two policies:
- **Strict mode.** Nothing is forwarded. Any pending write to a register that the decode-stage instruction reads holds that instruction until the producer has left the write-back stage.
- **Forwarding mode.** ALU-class consumers in the ALU stage take the value from the memory-stage result (Z4) or the write-back result (Z5). A stall is raised only where forwarding cannot help: a load or other non-ALU producer directly ahead of an ALU consumer, or any producer within two slots of a consumer that reads its operands in decode. In this mode the register file is assumed to pass a same-cycle write-back value through to a decode read.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Class codes are 0 nop, 1 alu, 2 load, 3 ladr, 4 brl, 5 store, 6 branch, 7 reserved (treated as nop); classes 1 to 4 write register ra. Select codes are 0 latched operand, 1 Z4, 2 Z5. With fwd_en=1, an alu in stage 3 whose rb equals ra of an alu in stage 4 gets x_sel=1.
- R2: With fwd_en=1 and an alu in stage 3, a source field equal to ra of a writing instruction (any of classes 1 to 4) in stage 5 selects Z5 (code 2), provided no writer in stage 4 matches that field.
- R3: When writers in both stage 4 (alu) and stage 5 match the same source field, Z4 (code 1) is selected.
- R4: y_sel follows the same rules using rc, but is 0 whenever the stage 3 instruction is an immediate form (s3_imm=1).
- R5: Both selects are 0 when fwd_en=0, when stage 3 is not an alu, when nothing matches, or when the matching stage-4 writer is not an alu.
- R6: Store, branch, nop and reserved classes in stages 3 to 5 never cause a forward or a stall.
- R7: pause_s1, pause_s2 and nop_s3 are always equal; together they form the stall.
- R8: With fwd_en=0, a stall is raised exactly when a writer in stage 3, 4 or 5 has ra equal to a source field that stage 2 uses. The used fields are rb for classes 1 to 6, rc for non-immediate alu and for branch and brl, and ra for store.
- R9: With fwd_en=1 and an alu in stage 2, a stall is raised exactly when stage 3 holds a writer other than alu whose ra matches a used field. This gives a one-slot load-use gap, after which Z5 supplies the value.
- R10: With fwd_en=1 and a stage-2 class of load, ladr, store, branch or brl, a stall is raised exactly when a writer in stage 3 or 4 matches a used field.
- R11: A nop or reserved class in stage 2 never stalls; all-zero inputs give all-zero outputs.
- R12: An immediate alu in stage 2 (s2_imm=1) ignores matches on rc when deciding a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fwd_en | input | 1 | 1 selects forwarding mode, 0 selects strict stall-only mode |
| s2_cls | input | 3 | class of the decode-stage instruction |
| s2_imm | input | 1 | decode-stage alu uses its constant as second operand |
| s2_ra | input | REG_W | decode-stage ra field (store data source) |
| s2_rb | input | REG_W | decode-stage rb field |
| s2_rc | input | REG_W | decode-stage rc field |
| s3_cls | input | 3 | class of the ALU-stage instruction |
| s3_imm | input | 1 | ALU-stage instruction is an immediate form |
| s3_ra | input | REG_W | ALU-stage destination register |
| s3_rb | input | REG_W | ALU-stage rb field carried for forwarding |
| s3_rc | input | REG_W | ALU-stage rc field carried for forwarding |
| s4_cls | input | 3 | class of the memory-stage instruction |
| s4_ra | input | REG_W | memory-stage destination register |
| s5_cls | input | 3 | class of the write-back-stage instruction |
| s5_ra | input | REG_W | write-back-stage destination register |
| x_sel | output | 2 | ALU X input select: 0 latched, 1 Z4, 2 Z5 |
| y_sel | output | 2 | ALU Y input select: 0 latched, 1 Z4, 2 Z5 |
| pause_s1 | output | 1 | hold the fetch-stage registers |
| pause_s2 | output | 1 | hold the decode-stage registers |
| nop_s3 | output | 1 | load a nop into the ALU stage |

## Verification
The hardest case to reach is an inconsistent mix of priorities. In it, a stage-4 writer that cannot be forwarded and a stage-5 writer both match the same ALU-stage field, or a matching stage-3 producer of one class sits in front of a stage-4 producer of another. A real pipeline rarely produces these. Random stimulus drawn uniformly over 32 registers would almost never produce them either. The stimulus therefore draws register numbers from a pool of four, so that matches across several stages are frequent. It also walks every class in every stage, in both modes. Directed items before the random run pin down each priority and gap case by hand.

// File: rtl/fhu_pkg.sv
package fhu_pkg;

    localparam int CLS_W = 3;
    localparam int SEL_W = 2;
    localparam int NSRC  = 3;   // rb, rc, ra as sources of stage 2
    localparam int NPROD = 3;   // producers in stages 3, 4, 5

    localparam logic [CLS_W-1:0] CL_NOP    = 3'd0;
    localparam logic [CLS_W-1:0] CL_ALU    = 3'd1;
    localparam logic [CLS_W-1:0] CL_LOAD   = 3'd2;
    localparam logic [CLS_W-1:0] CL_LADR   = 3'd3;
    localparam logic [CLS_W-1:0] CL_BRL    = 3'd4;
    localparam logic [CLS_W-1:0] CL_STORE  = 3'd5;
    localparam logic [CLS_W-1:0] CL_BRANCH = 3'd6;

    localparam logic [SEL_W-1:0] SEL_REG = 2'd0;
    localparam logic [SEL_W-1:0] SEL_Z4  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_Z5  = 2'd2;

    typedef struct packed {
        logic [NSRC-1:0]  used;
        logic [NPROD-1:0] hit;
        logic             stall;
    } fhu_stall_t;

    function automatic logic fhu_writes(input logic [CLS_W-1:0] c);
        return (c == CL_ALU) || (c == CL_LOAD) || (c == CL_LADR) || (c == CL_BRL);
    endfunction

endpackage

// File: rtl/fhu_operand_fwd.sv
module fhu_operand_fwd
    import fhu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             fwd_en,
    input  logic             cons_alu,
    input  logic             src_used,
    input  logic [REG_W-1:0] src_idx,
    input  logic [CLS_W-1:0] s4_cls,
    input  logic [REG_W-1:0] s4_ra,
    input  logic [CLS_W-1:0] s5_cls,
    input  logic [REG_W-1:0] s5_ra,
    output logic [SEL_W-1:0] sel
);

    logic             m4, m5;
    logic [SEL_W-1:0] sel_d;

    assign m4 = fhu_writes(s4_cls) && (s4_ra == src_idx);
    assign m5 = fhu_writes(s5_cls) && (s5_ra == src_idx);

    always_comb begin
        sel_d = SEL_REG;
        if (fwd_en && cons_alu && src_used) begin
            if (m4) begin
                // nearest writer wins; only an alu result is ready in Z4
                sel_d = (s4_cls == CL_ALU) ? SEL_Z4 : SEL_REG;
            end else if (m5) begin
                sel_d = SEL_Z5;
            end
        end
    end

    assign sel = sel_d;

    always_comb begin
        a_r5_off_no_fwd: assert (fwd_en || sel == SEL_REG)
            else $error("forward select active in strict mode");
        a_r1_z4_from_alu: assert (sel != SEL_Z4 || s4_cls == CL_ALU)
            else $error("Z4 chosen for a non-alu producer");
        a_r6_z5_from_writer: assert (sel != SEL_Z5 || fhu_writes(s5_cls))
            else $error("Z5 chosen for a non-writing class");
    end

endmodule

// File: rtl/fhu_stall_detect.sv
module fhu_stall_detect
    import fhu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             fwd_en,
    input  logic [CLS_W-1:0] s2_cls,
    input  logic             s2_imm,
    input  logic [REG_W-1:0] s2_ra,
    input  logic [REG_W-1:0] s2_rb,
    input  logic [REG_W-1:0] s2_rc,
    input  logic [CLS_W-1:0] s3_cls,
    input  logic [REG_W-1:0] s3_ra,
    input  logic [CLS_W-1:0] s4_cls,
    input  logic [REG_W-1:0] s4_ra,
    input  logic [CLS_W-1:0] s5_cls,
    input  logic [REG_W-1:0] s5_ra,
    output logic             stall
);

    logic [CLS_W-1:0] prod_cls [NPROD];
    logic [REG_W-1:0] prod_ra  [NPROD];
    logic [REG_W-1:0] src_idx  [NSRC];
    logic [NSRC-1:0]  used_w;
    logic [NPROD-1:0] hit_w;
    fhu_stall_t       st_d;

    assign prod_cls[0] = s3_cls;
    assign prod_cls[1] = s4_cls;
    assign prod_cls[2] = s5_cls;
    assign prod_ra[0]  = s3_ra;
    assign prod_ra[1]  = s4_ra;
    assign prod_ra[2]  = s5_ra;

    assign src_idx[0] = s2_rb;
    assign src_idx[1] = s2_rc;
    assign src_idx[2] = s2_ra;

    assign used_w[0] = (s2_cls != CL_NOP) && (s2_cls <= CL_BRANCH);
    assign used_w[1] = ((s2_cls == CL_ALU) && !s2_imm) ||
                       (s2_cls == CL_BRANCH) || (s2_cls == CL_BRL);
    assign used_w[2] = (s2_cls == CL_STORE);

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        logic [NSRC-1:0] eq;
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign eq[s] = used_w[s] && (prod_ra[p] == src_idx[s]);
        end
        assign hit_w[p] = fhu_writes(prod_cls[p]) && (|eq);
    end

    always_comb begin
        st_d       = '0;
        st_d.used  = used_w;
        st_d.hit   = hit_w;
        if (!fwd_en) begin
            st_d.stall = |st_d.hit;
        end else if (s2_cls == CL_ALU) begin
            st_d.stall = st_d.hit[0] && (s3_cls != CL_ALU);
        end else begin
            st_d.stall = st_d.hit[0] || st_d.hit[1];
        end
    end

    assign stall = st_d.stall;

    always_comb begin
        a_r11_nop_never_stalls: assert (!(s2_cls == CL_NOP || s2_cls == 3'd7) || !stall)
            else $error("stall raised for an empty decode slot");
        a_r10_stage5_free_in_fwd: assert (!(fwd_en && stall) || hit_w[0] || hit_w[1])
            else $error("forwarding-mode stall without a stage 3/4 hit");
    end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fhu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             fwd_en,
    input  logic [2:0]       s2_cls,
    input  logic             s2_imm,
    input  logic [REG_W-1:0] s2_ra,
    input  logic [REG_W-1:0] s2_rb,
    input  logic [REG_W-1:0] s2_rc,
    input  logic [2:0]       s3_cls,
    input  logic             s3_imm,
    input  logic [REG_W-1:0] s3_ra,
    input  logic [REG_W-1:0] s3_rb,
    input  logic [REG_W-1:0] s3_rc,
    input  logic [2:0]       s4_cls,
    input  logic [REG_W-1:0] s4_ra,
    input  logic [2:0]       s5_cls,
    input  logic [REG_W-1:0] s5_ra,
    output logic [1:0]       x_sel,
    output logic [1:0]       y_sel,
    output logic             pause_s1,
    output logic             pause_s2,
    output logic             nop_s3
);

    localparam int LANES = 2;   // lane 0 feeds X, lane 1 feeds Y

    logic [REG_W-1:0] lane_idx  [LANES];
    logic [LANES-1:0] lane_used;
    logic [SEL_W-1:0] lane_sel  [LANES];
    logic             stall_w;

    assign lane_idx[0]  = s3_rb;
    assign lane_idx[1]  = s3_rc;
    assign lane_used[0] = 1'b1;
    assign lane_used[1] = !s3_imm;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fhu_operand_fwd #(.REG_W(REG_W)) u_fwd (
            .fwd_en   (fwd_en),
            .cons_alu (s3_cls == CL_ALU),
            .src_used (lane_used[l]),
            .src_idx  (lane_idx[l]),
            .s4_cls   (s4_cls),
            .s4_ra    (s4_ra),
            .s5_cls   (s5_cls),
            .s5_ra    (s5_ra),
            .sel      (lane_sel[l])
        );
    end

    fhu_stall_detect #(.REG_W(REG_W)) u_stall (
        .fwd_en (fwd_en),
        .s2_cls (s2_cls),
        .s2_imm (s2_imm),
        .s2_ra  (s2_ra),
        .s2_rb  (s2_rb),
        .s2_rc  (s2_rc),
        .s3_cls (s3_cls),
        .s3_ra  (s3_ra),
        .s4_cls (s4_cls),
        .s4_ra  (s4_ra),
        .s5_cls (s5_cls),
        .s5_ra  (s5_ra),
        .stall  (stall_w)
    );

    assign x_sel    = lane_sel[0];
    assign y_sel    = lane_sel[1];
    assign pause_s1 = stall_w;
    assign pause_s2 = stall_w;
    assign nop_s3   = stall_w;

    always_comb begin
        a_r4_imm_keeps_y: assert (!s3_imm || y_sel == SEL_REG)
            else $error("Y forwarded for an immediate form");
        a_r9_alu_stall_cause: assert (!(fwd_en && s2_cls == CL_ALU && pause_s2) ||
                                      (fhu_writes(s3_cls) && s3_cls != CL_ALU))
            else $error("alu consumer stalled behind a forwardable producer");
        a_r12_imm_rc_ignored: assert (!(s2_cls == CL_ALU && s2_imm && s2_rc != s2_rb &&
                                        pause_s2) || s3_ra == s2_rb || s4_ra == s2_rb ||
                                        s5_ra == s2_rb)
            else $error("stall from rc on an immediate alu");
    end

endmodule

// File: tb/fwd_hazard_unit_bench.sv
`timescale 1ns/1ps
module fwd_hazard_unit_bench;

    localparam int RW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          fwd_en = 1'b0;
    logic [2:0]    s2_cls = '0, s3_cls = '0, s4_cls = '0, s5_cls = '0;
    logic          s2_imm = 1'b0, s3_imm = 1'b0;
    logic [RW-1:0] s2_ra = '0, s2_rb = '0, s2_rc = '0;
    logic [RW-1:0] s3_ra = '0, s3_rb = '0, s3_rc = '0;
    logic [RW-1:0] s4_ra = '0, s5_ra = '0;
    logic [1:0]    x_sel, y_sel;
    logic          pause_s1, pause_s2, nop_s3;

    fwd_hazard_unit #(.REG_W(RW)) u_fwd_hazard_unit (
        .fwd_en, .s2_cls, .s2_imm, .s2_ra, .s2_rb, .s2_rc,
        .s3_cls, .s3_imm, .s3_ra, .s3_rb, .s3_rc,
        .s4_cls, .s4_ra, .s5_cls, .s5_ra,
        .x_sel, .y_sel, .pause_s1, .pause_s2, .nop_s3
    );

    logic [1:0] qx[$];
    logic [1:0] qy[$];
    logic       qs[$];
    string      qt[$];
    int checks = 0, fails = 0;
    bit drv_done = 0, all_done = 0;

    function automatic bit is_wr(logic [2:0] c);
        case (c)
            3'd1, 3'd2, 3'd3, 3'd4: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] ref_fwd(bit on, logic [RW-1:0] idx);
        logic [1:0] r;
        r = 2'd0;
        if (fwd_en && s3_cls == 3'd1 && on) begin
            if (is_wr(s4_cls) && s4_ra == idx)      r = (s4_cls == 3'd1) ? 2'd1 : 2'd0;
            else if (is_wr(s5_cls) && s5_ra == idx) r = 2'd2;
        end
        return r;
    endfunction

    function automatic bit reads(logic [RW-1:0] r);
        bit u;
        u = 1'b0;
        if (s2_cls >= 3'd1 && s2_cls <= 3'd6 && s2_rb == r) u = 1'b1;
        if (s2_rc == r && ((s2_cls == 3'd1 && !s2_imm) || s2_cls == 3'd6 || s2_cls == 3'd4)) u = 1'b1;
        if (s2_cls == 3'd5 && s2_ra == r) u = 1'b1;
        return u;
    endfunction

    function automatic bit ref_stall();
        bit h3, h4, h5;
        h3 = is_wr(s3_cls) && reads(s3_ra);
        h4 = is_wr(s4_cls) && reads(s4_ra);
        h5 = is_wr(s5_cls) && reads(s5_ra);
        if (!fwd_en)            return h3 | h4 | h5;
        if (s2_cls == 3'd1)     return h3 && s3_cls != 3'd1;
        return h3 | h4;
    endfunction

    task automatic push(string tag);
        qx.push_back(ref_fwd(1'b1, s3_rb));
        qy.push_back(ref_fwd(!s3_imm, s3_rc));
        qs.push_back(ref_stall());
        qt.push_back(tag);
    endtask

    task automatic clear();
        fwd_en = 1'b1;
        s2_cls = 0; s3_cls = 0; s4_cls = 0; s5_cls = 0;
        s2_imm = 0; s3_imm = 0;
        s2_ra = 0; s2_rb = 0; s2_rc = 0;
        s3_ra = 0; s3_rb = 0; s3_rc = 0;
        s4_ra = 0; s5_ra = 0;
    endtask

    // monitor: compare one item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (qx.size() > 0) begin
                logic [1:0] ex, ey;
                logic es;
                string t;
                ex = qx.pop_front(); ey = qy.pop_front();
                es = qs.pop_front(); t = qt.pop_front();
                checks++;
                if (x_sel !== ex || y_sel !== ey) begin
                    fails++;
                    $display("FAIL %s: x_sel=%0d y_sel=%0d expected x_sel=%0d y_sel=%0d",
                             t, x_sel, y_sel, ex, ey);
                end else if (pause_s1 !== es || pause_s2 !== es || nop_s3 !== es) begin
                    fails++;
                    $display("FAIL %s (R7 stall lines): pause_s1=%0b pause_s2=%0b nop_s3=%0b expected %0b",
                             t, pause_s1, pause_s2, nop_s3, es);
                end
            end else if (drv_done) begin
                all_done = 1;
            end
        end
    end

    // driver
    initial begin
        clear();
        @(posedge clk); push("R11 idle all-zero");
        // R1: Z4 to X
        @(posedge clk); clear(); s3_cls = 1; s3_rb = 3; s3_rc = 4; s4_cls = 1; s4_ra = 3;
        push("R1 alu->alu Z4 on X");
        // R2: Z5 from a load to Y
        @(posedge clk); clear(); s3_cls = 1; s3_rb = 3; s3_rc = 4; s5_cls = 2; s5_ra = 4;
        push("R2 load Z5 on Y");
        // R3: both match, Z4 wins
        @(posedge clk); clear(); s3_cls = 1; s3_rb = 3; s4_cls = 1; s4_ra = 3; s5_cls = 1; s5_ra = 3;
        push("R3 Z4 priority");
        // R4: immediate form keeps Y latched
        @(posedge clk); clear(); s3_cls = 1; s3_imm = 1; s3_rb = 2; s3_rc = 4; s4_cls = 1; s4_ra = 4;
        push("R4 immediate Y");
        // R5: strict mode and non-alu stage-4 producer
        @(posedge clk); clear(); fwd_en = 0; s3_cls = 1; s3_rb = 3; s4_cls = 1; s4_ra = 3;
        push("R5 strict mode no forward");
        @(posedge clk); clear(); s3_cls = 1; s3_rb = 3; s4_cls = 3; s4_ra = 3; s5_cls = 1; s5_ra = 3;
        push("R5 ladr in stage 4 blocks forward");
        @(posedge clk); clear(); s3_cls = 5; s3_rb = 3; s4_cls = 1; s4_ra = 3;
        push("R5 store consumer no forward");
        // R6: non-writers never forward or stall
        @(posedge clk); clear(); s3_cls = 1; s3_rb = 3; s4_cls = 5; s4_ra = 3; s5_cls = 6; s5_ra = 3;
        push("R6 store/branch producers");
        @(posedge clk); clear(); fwd_en = 0; s2_cls = 1; s2_rb = 6; s3_cls = 5; s3_ra = 6; s4_cls = 7; s4_ra = 6;
        push("R6 no stall from store/reserved");
        // R8: strict-mode stalls over three stages
        @(posedge clk); clear(); fwd_en = 0; s2_cls = 1; s2_rb = 7; s5_cls = 1; s5_ra = 7;
        push("R8 strict stage 5 hit");
        @(posedge clk); clear(); fwd_en = 0; s2_cls = 5; s2_ra = 8; s4_cls = 2; s4_ra = 8;
        push("R8 strict store data hit");
        // R9: load-use in forwarding mode
        @(posedge clk); clear(); s2_cls = 1; s2_rb = 7; s3_cls = 2; s3_ra = 7;
        push("R9 load-use stall");
        @(posedge clk); clear(); s2_cls = 1; s2_rb = 7; s3_cls = 1; s3_ra = 7;
        push("R9 alu-alu no stall");
        @(posedge clk); clear(); s2_cls = 1; s2_rb = 7; s4_cls = 2; s4_ra = 7;
        push("R9 load two ahead no stall");
        // R10: operand-in-decode consumers
        @(posedge clk); clear(); s2_cls = 6; s2_rb = 9; s4_cls = 2; s4_ra = 9;
        push("R10 branch after load gap");
        @(posedge clk); clear(); s2_cls = 6; s2_rb = 9; s5_cls = 1; s5_ra = 9;
        push("R10 branch stage 5 free");
        @(posedge clk); clear(); s2_cls = 5; s2_ra = 6; s3_cls = 1; s3_ra = 6;
        push("R10 store data behind alu");
        // R11: empty decode slot
        @(posedge clk); clear(); fwd_en = 0; s2_cls = 0; s3_cls = 1; s4_cls = 2; s5_cls = 3;
        push("R11 nop in decode");
        // R12: immediate alu ignores rc
        @(posedge clk); clear(); fwd_en = 0; s2_cls = 1; s2_imm = 1; s2_rb = 1; s2_rc = 5; s3_cls = 1; s3_ra = 5;
        push("R12 imm rc ignored");
        @(posedge clk); s2_imm = 0;
        push("R12 non-imm rc stalls");
        // random mix over a small register pool
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk);
            fwd_en = 1'($urandom);
            s2_cls = 3'($urandom); s3_cls = 3'($urandom);
            s4_cls = 3'($urandom); s5_cls = 3'($urandom);
            s2_imm = 1'($urandom); s3_imm = 1'($urandom);
            s2_ra = RW'($urandom % 4); s2_rb = RW'($urandom % 4); s2_rc = RW'($urandom % 4);
            s3_ra = RW'($urandom % 4); s3_rb = RW'($urandom % 4); s3_rc = RW'($urandom % 4);
            s4_ra = RW'($urandom % 4); s5_ra = RW'($urandom % 4);
            push("RND");
        end
        drv_done = 1;
    end

    initial begin
        fork
            begin
                wait (all_done);
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule